// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block is the producer side of an interrupt ring shared with a host. Interrupt sources hand it 128-bit vectors over a valid/ready handshake. For each vector it issues four 32-bit memory write beats into a circular buffer, at the ring start address plus the current write offset. It then advances the write offset by 16 bytes, wrapping at the programmed ring size. If the advance lands on the host's read offset, the block raises an overflow flag. If writeback is enabled, it then issues one more beat that copies the write-offset register to a separate host-visible address.

The host programs the ring through a small register port: the ring start, the size control, the writeback address and the read offset. The host consumes vectors and moves its read offset by writing that register. An interrupt request line follows the ring state. An optional rearm mode gives the line a fresh edge whenever the host updates its read offset while vectors remain unread.

Top module: `irq_vec_ring`

## Requirements
- R1: After reset both offsets read zero, the overflow flag is clear, `irq_req` is low, `mem_req_valid` is low and `vec_ready` is high.
- R2: `vec_ready` is high only while no vector is in progress. An accepted vector produces four write beats in word order: word k carries `vec_data[32k+31:32k]` at address {base register, 8'h00} + write offset + 4k.
- R3: The write offset (register offset 5, bits below 31) advances by 16 modulo the ring size in the same clock edge that accepts the fourth beat, and at no other time. The ring size is 4 << n bytes, where n is control bits [4:0] clamped to the range 2 to MAX_LOG2_WORDS.
- R4: If the advanced write offset equals the read offset, bit 31 of the write-offset register (the overflow flag) is set. The vector is still written in full, the read offset is not changed, and the flag stays set until it is cleared.
- R5: While control bit 8 is 1, the overflow flag is forced to 0 from the next cycle on and cannot be set.
- R6: With control bit 9 set, each vector is followed by one extra beat at {register 3 [7:0], register 2} whose data is the write-offset register value including the flag. With bit 9 clear, no extra beat is issued.
- R7: A write to register offset 4 sets the read offset to the written value ANDed with the ring mask and with the 16-byte alignment, and register offset 4 reads back that value.
- R8: `irq_req` is high in the cycle after each write-offset advance. It is low in the cycle after a read-offset write that makes the read offset equal to the write offset.
- R9: A read-offset write that leaves the offsets unequal has two possible effects. With control bit 10 (rearm) set, `irq_req` is low for one cycle and then high. With bit 10 clear, `irq_req` keeps its value.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with the same address and data in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_valid | input | 1 | Source offers a vector |
| vec_ready | output | 1 | Block can take a vector |
| vec_data | input | 128 | Interrupt vector, word 0 in the low bits |
| mem_req_valid | output | 1 | Memory write beat valid |
| mem_req_ready | input | 1 | Memory accepts the beat |
| mem_req_addr | output | 40 | Byte address of the beat |
| mem_req_data | output | 32 | Beat data |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset (0 base, 1 control, 2 writeback low, 3 writeback high, 4 read offset, 5 write offset) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_req | output | 1 | Interrupt request to the host |

## Verification
A wrong write offset appears at the ports on the very next vector, as a shifted beat address. It also appears in the writeback beat that follows the advance, and in a readback of register offset 5 one cycle after the fourth beat. A wrong overflow flag shows in bit 31 of the same writeback data and readback, and the wrong value persists until the clear bit is set. A wrong interrupt state shows on `irq_req` one cycle after an advance or a read-offset write. The rearm gap is visible only in the single cycle that follows the write.

// File: rtl/irqring_pkg.sv
package irqring_pkg;
   localparam int unsigned VEC_WORDS = 4;
   localparam int unsigned VEC_BYTES = VEC_WORDS * 4;
   localparam int unsigned VEC_W     = VEC_WORDS * 32;
   localparam int unsigned MEM_AW    = 40;
   localparam int unsigned ALIGN_LSB = 8;

   localparam logic [2:0] OFS_BASE = 3'd0;
   localparam logic [2:0] OFS_CTRL = 3'd1;
   localparam logic [2:0] OFS_WBLO = 3'd2;
   localparam logic [2:0] OFS_WBHI = 3'd3;
   localparam logic [2:0] OFS_RPTR = 3'd4;
   localparam logic [2:0] OFS_WPTR = 3'd5;

   localparam int unsigned CB_CLR   = 8;
   localparam int unsigned CB_WB    = 9;
   localparam int unsigned CB_REARM = 10;
   localparam int unsigned FLAG_BIT = 31;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WORD = 2'd1,
      ST_WB   = 2'd2
   } seq_state_e;
endpackage

// File: rtl/irqring_regs.sv
module irqring_regs
   import irqring_pkg::*;
#(
   parameter int unsigned MAX_LOG2_WORDS = 10,
   parameter int unsigned PTR_W          = MAX_LOG2_WORDS + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr_en,
   input  logic [2:0]          reg_addr,
   input  logic [31:0]         reg_wdata,
   input  logic [31:0]         wptr_word,
   output logic [31:0]         reg_rdata,
   output logic [MEM_AW-1:0]   ring_base,
   output logic [MEM_AW-1:0]   wb_addr,
   output logic [PTR_W-1:0]    ring_mask,
   output logic                ovf_clr,
   output logic                wb_en,
   output logic                rearm,
   output logic [PTR_W-1:0]    rptr,
   output logic                rptr_we,
   output logic [PTR_W-1:0]    rptr_wdata
);
   localparam logic [PTR_W:0]   FOUR      = (PTR_W+1)'(4);
   localparam logic [PTR_W-1:0] ALIGN_MSK = ~(PTR_W'(VEC_BYTES - 1));
   localparam logic [4:0]       SZ_MIN    = 5'd2;
   localparam logic [4:0]       SZ_MAX    = 5'(MAX_LOG2_WORDS);

   logic [31:0]      base_q;
   logic [31:0]      wblo_q;
   logic [7:0]       wbhi_q;
   logic [4:0]       sz_q;
   logic             clr_q, wb_q, rearm_q;
   logic [PTR_W-1:0] rptr_q;
   logic [4:0]       sz_eff;
   logic [PTR_W:0]   ring_bytes;
   logic [PTR_W:0]   bytes_m1;

   always_comb begin
      if (sz_q < SZ_MIN)      sz_eff = SZ_MIN;
      else if (sz_q > SZ_MAX) sz_eff = SZ_MAX;
      else                    sz_eff = sz_q;
   end

   assign ring_bytes = FOUR << sz_eff;
   assign bytes_m1   = ring_bytes - 1'b1;
   assign ring_mask  = bytes_m1[PTR_W-1:0];
   assign rptr_wdata = reg_wdata[PTR_W-1:0] & ring_mask & ALIGN_MSK;
   assign rptr_we    = reg_wr_en && (reg_addr == OFS_RPTR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         wblo_q  <= '0;
         wbhi_q  <= '0;
         sz_q    <= '0;
         clr_q   <= 1'b0;
         wb_q    <= 1'b0;
         rearm_q <= 1'b0;
         rptr_q  <= '0;
      end else if (reg_wr_en) begin
         case (reg_addr)
            OFS_BASE: base_q <= reg_wdata;
            OFS_CTRL: begin
               sz_q    <= reg_wdata[4:0];
               clr_q   <= reg_wdata[CB_CLR];
               wb_q    <= reg_wdata[CB_WB];
               rearm_q <= reg_wdata[CB_REARM];
            end
            OFS_WBLO: wblo_q <= reg_wdata;
            OFS_WBHI: wbhi_q <= reg_wdata[7:0];
            OFS_RPTR: rptr_q <= rptr_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (reg_addr)
         OFS_BASE: reg_rdata = base_q;
         OFS_CTRL: reg_rdata = {21'd0, rearm_q, wb_q, clr_q, 3'd0, sz_q};
         OFS_WBLO: reg_rdata = wblo_q;
         OFS_WBHI: reg_rdata = {24'd0, wbhi_q};
         OFS_RPTR: reg_rdata = {{(32-PTR_W){1'b0}}, rptr_q};
         OFS_WPTR: reg_rdata = wptr_word;
         default:  reg_rdata = '0;
      endcase
   end

   assign ring_base = {base_q, {ALIGN_LSB{1'b0}}};
   assign wb_addr   = {wbhi_q, wblo_q};
   assign ovf_clr   = clr_q;
   assign wb_en     = wb_q;
   assign rearm     = rearm_q;
   assign rptr      = rptr_q;
endmodule

// File: rtl/irqring_ptr.sv
module irqring_ptr
   import irqring_pkg::*;
#(
   parameter int unsigned PTR_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [PTR_W-1:0] ring_mask,
   input  logic [PTR_W-1:0] rptr,
   input  logic             rptr_we,
   input  logic [PTR_W-1:0] rptr_wdata,
   input  logic             ovf_clr,
   input  logic             rearm,
   output logic [PTR_W-1:0] wptr,
   output logic             ovf_flag,
   output logic             irq,
   output logic [31:0]      wptr_word
);
   localparam logic [PTR_W-1:0] STEP = PTR_W'(VEC_BYTES);

   logic [PTR_W-1:0] wptr_q;
   logic [PTR_W-1:0] wptr_next;
   logic             ovf_q;
   logic             irq_q;
   logic             gap_q;

   assign wptr_next = (wptr_q + STEP) & ring_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (adv) wptr_q <= wptr_next;
         if (ovf_clr)                          ovf_q <= 1'b0;
         else if (adv && (wptr_next == rptr))  ovf_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         gap_q <= 1'b0;
      end else if (adv) begin
         irq_q <= 1'b1;
         gap_q <= 1'b0;
      end else if (rptr_we) begin
         if (rptr_wdata == wptr_q) begin
            irq_q <= 1'b0;
            gap_q <= 1'b0;
         end else if (rearm) begin
            irq_q <= 1'b0;
            gap_q <= 1'b1;
         end
      end else if (gap_q) begin
         irq_q <= (rptr != wptr_q);
         gap_q <= 1'b0;
      end
   end

   assign wptr      = wptr_q;
   assign ovf_flag  = ovf_q;
   assign irq       = irq_q;
   assign wptr_word = {ovf_q, {(FLAG_BIT-PTR_W){1'b0}}, wptr_q};
endmodule

// File: rtl/irqring_seq.sv
module irqring_seq
   import irqring_pkg::*;
#(
   parameter int unsigned PTR_W      = 12,
   parameter bit          WB_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vec_valid,
   input  logic [VEC_W-1:0]  vec_data,
   output logic              vec_ready,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [31:0]       mem_data,
   input  logic [MEM_AW-1:0] ring_base,
   input  logic [MEM_AW-1:0] wb_addr,
   input  logic              wb_en,
   input  logic [PTR_W-1:0]  wptr,
   input  logic [31:0]       wptr_word,
   output logic              adv
);
   localparam int unsigned IDX_W = $clog2(VEC_WORDS);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(VEC_WORDS - 1);

   seq_state_e       st_q;
   logic [IDX_W-1:0] widx_q;
   logic [VEC_W-1:0] vec_q;
   logic             wb_go;

   generate
      if (WB_SUPPORT) begin : g_wb
         assign wb_go = wb_en;
      end else begin : g_nowb
         assign wb_go = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         widx_q <= '0;
         vec_q  <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (vec_valid) begin
               vec_q  <= vec_data;
               widx_q <= '0;
               st_q   <= ST_WORD;
            end
            ST_WORD: if (mem_ready) begin
               if (widx_q == LAST) st_q <= wb_go ? ST_WB : ST_IDLE;
               else                widx_q <= widx_q + 1'b1;
            end
            ST_WB: if (mem_ready) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign adv       = (st_q == ST_WORD) && mem_ready && (widx_q == LAST);
   assign vec_ready = (st_q == ST_IDLE);
   assign mem_valid = (st_q != ST_IDLE);

   always_comb begin
      if (st_q == ST_WB) begin
         mem_addr = wb_addr;
         mem_data = wptr_word;
      end else begin
         mem_addr = ring_base + {{(MEM_AW-PTR_W){1'b0}}, wptr}
                              + {{(MEM_AW-IDX_W-2){1'b0}}, widx_q, 2'b00};
         mem_data = vec_q[{widx_q, 5'b00000} +: 32];
      end
   end
endmodule

// File: rtl/irq_vec_ring.sv
module irq_vec_ring
   import irqring_pkg::*;
#(
   parameter int unsigned MAX_LOG2_WORDS = 10,
   parameter bit          WB_SUPPORT     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vec_valid,
   output logic          vec_ready,
   input  logic [127:0]  vec_data,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic [39:0]   mem_req_addr,
   output logic [31:0]   mem_req_data,
   input  logic          reg_wr_en,
   input  logic [2:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          irq_req
);
   localparam int unsigned PTR_W = MAX_LOG2_WORDS + 2;

   generate
      if (MAX_LOG2_WORDS < 2 || MAX_LOG2_WORDS > 28) begin : g_bad_size
         $error("MAX_LOG2_WORDS must lie in 2..28");
      end
      if (VEC_W != 128 || MEM_AW != 40) begin : g_bad_shape
         $error("vector or address width differs from the port widths");
      end
   endgenerate

   logic [MEM_AW-1:0] ring_base, wb_addr;
   logic [PTR_W-1:0]  ring_mask, rptr, rptr_wdata, wptr;
   logic              ovf_clr, wb_en, rearm, rptr_we;
   logic              ovf_flag, adv;
   logic [31:0]       wptr_word;

   irqring_regs #(.MAX_LOG2_WORDS(MAX_LOG2_WORDS), .PTR_W(PTR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .wptr_word(wptr_word), .reg_rdata(reg_rdata),
      .ring_base(ring_base), .wb_addr(wb_addr), .ring_mask(ring_mask),
      .ovf_clr(ovf_clr), .wb_en(wb_en), .rearm(rearm),
      .rptr(rptr), .rptr_we(rptr_we), .rptr_wdata(rptr_wdata)
   );

   irqring_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .adv(adv), .ring_mask(ring_mask),
      .rptr(rptr), .rptr_we(rptr_we), .rptr_wdata(rptr_wdata),
      .ovf_clr(ovf_clr), .rearm(rearm),
      .wptr(wptr), .ovf_flag(ovf_flag), .irq(irq_req), .wptr_word(wptr_word)
   );

   irqring_seq #(.PTR_W(PTR_W), .WB_SUPPORT(WB_SUPPORT)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .vec_valid(vec_valid), .vec_data(vec_data), .vec_ready(vec_ready),
      .mem_valid(mem_req_valid), .mem_ready(mem_req_ready),
      .mem_addr(mem_req_addr), .mem_data(mem_req_data),
      .ring_base(ring_base), .wb_addr(wb_addr), .wb_en(wb_en),
      .wptr(wptr), .wptr_word(wptr_word), .adv(adv)
   );
endmodule

// File: rtl/irq_vec_ring_chk.sv
module irq_vec_ring_chk #(
   parameter int unsigned PTR_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             adv,
   input logic [PTR_W-1:0] wptr,
   input logic [PTR_W-1:0] ring_mask,
   input logic [PTR_W-1:0] rptr,
   input logic             rptr_we,
   input logic             ovf_flag,
   input logic             ovf_clr,
   input logic             irq_req,
   input logic             vec_ready,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [39:0]      mem_req_addr,
   input logic [31:0]      mem_req_data
);
   p_wptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> wptr == (($past(wptr) + PTR_W'(16)) & $past(ring_mask)));

   p_wptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(wptr));

   p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag && !ovf_clr |=> ovf_flag);

   p_rptr_host_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rptr_we |=> $stable(rptr));

   p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_clr |=> !ovf_flag);

   p_irq_after_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> irq_req);

   p_busy_no_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      vec_ready |-> !mem_req_valid);

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=>
         mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data));
endmodule

bind irq_vec_ring irq_vec_ring_chk #(.PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .adv(adv), .wptr(wptr), .ring_mask(ring_mask),
   .rptr(rptr), .rptr_we(rptr_we), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr),
   .irq_req(irq_req), .vec_ready(vec_ready),
   .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data)
);

// File: tb/irq_vec_ring_bench.sv
`timescale 1ns/1ps
module irq_vec_ring_bench;
   localparam int unsigned MAXL = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         vec_valid = 1'b0;
   logic         vec_ready;
   logic [127:0] vec_data = '0;
   logic         mem_req_valid;
   logic         mem_req_ready = 1'b0;
   logic [39:0]  mem_req_addr;
   logic [31:0]  mem_req_data;
   logic         reg_wr_en = 1'b0;
   logic [2:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         irq_req;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_base, m_mask, m_wptr, m_rptr, m_wblo;
   logic [7:0]  m_wbhi;
   logic        m_ovf, m_clr, m_wb, m_rearm, m_irq;

   always #2.5 clk = ~clk;

   irq_vec_ring #(.MAX_LOG2_WORDS(MAXL)) u_irq_vec_ring (
      .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_ready(vec_ready),
      .vec_data(vec_data), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_req_data(mem_req_data), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req)
   );

   function automatic logic [31:0] f_mask(input logic [4:0] sz);
      int unsigned e;
      e = (sz < 2) ? 2 : ((sz > MAXL) ? MAXL : int'(sz));
      return (32'd4 << e) - 32'd1;
   endfunction

   function automatic logic [31:0] f_wword();
      return {m_ovf, m_wptr[30:0]};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic set_ctrl(input logic [4:0] sz, input logic clr,
                           input logic wb, input logic rearm);
      wr_reg(3'd1, {21'd0, rearm, wb, clr, 3'd0, sz});
      m_mask = f_mask(sz); m_clr = clr; m_wb = wb; m_rearm = rearm;
      if (clr) m_ovf = 1'b0;
      @(negedge clk);
   endtask

   task automatic check_wptr(input string req);
      logic [31:0] v;
      rd(3'd5, v);
      chk(v == f_wword(), req, "wptr register", 64'(v), 64'(f_wword()));
   endtask

   task automatic host_rptr(input logic [31:0] d);
      logic [31:0] nv, v;
      logic        ex, gap;
      nv = d & m_mask & ~32'hF;
      gap = 1'b0;
      if (nv == m_wptr) ex = 1'b0;
      else if (m_rearm) begin ex = 1'b0; gap = 1'b1; end
      else ex = m_irq;
      wr_reg(3'd4, d);
      m_rptr = nv;
      chk(irq_req == ex, gap ? "R9" : "R8", "irq after rptr write",
          64'(irq_req), 64'(ex));
      rd(3'd4, v);
      chk(v == nv, "R7", "rptr readback", 64'(v), 64'(nv));
      if (gap) begin
         @(negedge clk);
         chk(irq_req == 1'b1, "R9", "irq rearmed", 64'(irq_req), 64'd1);
         m_irq = 1'b1;
      end else m_irq = ex;
   endtask

   task automatic send_vec(input logic [127:0] v);
      int k, n;
      logic [39:0] ea, pa;
      logic [31:0] ed, pd;
      bit stalled;
      @(negedge clk);
      chk(vec_ready == 1'b1, "R2", "vec_ready idle", 64'(vec_ready), 64'd1);
      vec_valid = 1'b1; vec_data = v;
      @(negedge clk);
      vec_valid = 1'b0;
      k = 0; n = m_wb ? 5 : 4; stalled = 0; pa = '0; pd = '0;
      while (k < n) begin
         if (stalled)
            chk(mem_req_valid && mem_req_addr == pa && mem_req_data == pd, "R10",
                "held beat", {mem_req_data, mem_req_addr[31:0]}, {pd, pa[31:0]});
         mem_req_ready = ($urandom % 4) != 0;
         if (mem_req_valid && mem_req_ready) begin
            if (k < 4) begin
               ea = {m_base, 8'h00} + 40'(m_wptr) + 40'(4 * k);
               ed = v[32*k +: 32];
               chk(mem_req_addr == ea && mem_req_data == ed, "R2", "vector beat",
                   {mem_req_data, mem_req_addr[31:0]}, {ed, ea[31:0]});
            end else begin
               ea = {m_wbhi, m_wblo};
               ed = f_wword();
               chk(mem_req_addr == ea && mem_req_data == ed, "R6", "writeback beat",
                   {mem_req_data, mem_req_addr[31:0]}, {ed, ea[31:0]});
            end
            k++;
            if (k == 4) begin
               m_wptr = (m_wptr + 32'd16) & m_mask;
               if (m_clr) m_ovf = 1'b0;
               else if (m_wptr == m_rptr) m_ovf = 1'b1;
               m_irq = 1'b1;
            end
            stalled = 0;
         end else begin
            stalled = mem_req_valid;
            pa = mem_req_addr; pd = mem_req_data;
         end
         @(negedge clk);
      end
      chk(irq_req == 1'b1, "R8", "irq after advance", 64'(irq_req), 64'd1);
      check_wptr("R3");
   endtask

   function automatic logic [127:0] rnd_vec();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog all act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd1234));
      m_base = 0; m_mask = f_mask(5'd0); m_wptr = 0; m_rptr = 0; m_wblo = 0;
      m_wbhi = 0; m_ovf = 0; m_clr = 0; m_wb = 0; m_rearm = 0; m_irq = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_wptr("R1");
      rd(3'd4, v);
      chk(v == 0, "R1", "rptr reset", 64'(v), 64'd0);
      chk(!irq_req && !mem_req_valid && vec_ready, "R1", "irq/valid/ready",
          {61'd0, irq_req, mem_req_valid, vec_ready}, 64'd1);

      // configure: 64-byte ring, writeback on
      wr_reg(3'd0, 32'h0001_2345); m_base = 32'h0001_2345;
      wr_reg(3'd2, 32'hCAFE_0000); m_wblo = 32'hCAFE_0000;
      wr_reg(3'd3, 32'h0000_017F); m_wbhi = 8'h7F;
      set_ctrl(5'd4, 1'b0, 1'b1, 1'b0);
      for (int i = 0; i < 3; i++) send_vec(rnd_vec());
      host_rptr(32'd48);                       // R8 idle drops irq
      for (int i = 0; i < 4; i++) send_vec(rnd_vec());   // R4 wrap onto rptr
      chk(m_ovf == 1'b1, "R4", "model flag expected set", 64'(m_ovf), 64'd1);
      rd(3'd4, v);
      chk(v == 32'd48, "R4", "rptr untouched", 64'(v), 64'd48);
      send_vec(rnd_vec());                     // R4 sticky
      set_ctrl(5'd4, 1'b1, 1'b1, 1'b0);        // R5 clear
      check_wptr("R5");
      for (int i = 0; i < 3; i++) send_vec(rnd_vec());   // R5 no set while clearing
      set_ctrl(5'd4, 1'b0, 1'b1, 1'b1);
      host_rptr(32'd16);                       // R9 rearm gap
      set_ctrl(5'd4, 1'b0, 1'b1, 1'b0);
      host_rptr(32'd32);                       // R9 unchanged
      set_ctrl(5'd4, 1'b0, 1'b0, 1'b0);
      send_vec(rnd_vec());                     // R6 no writeback beat
      for (int i = 0; i < 3; i++) begin
         chk(!mem_req_valid, "R6", "no extra beat", 64'(mem_req_valid), 64'd0);
         @(negedge clk);
      end
      host_rptr(32'hFFFF_FFFF);                // R7 masking
      set_ctrl(5'd0, 1'b0, 1'b1, 1'b0);        // R3 low clamp: 16-byte ring
      host_rptr(32'd0);
      send_vec(rnd_vec());
      send_vec(rnd_vec());
      set_ctrl(5'd31, 1'b1, 1'b1, 1'b0);       // R3 high clamp
      set_ctrl(5'd31, 1'b0, 1'b1, 1'b0);
      host_rptr(32'h800);
      for (int i = 0; i < 256; i++) send_vec(rnd_vec());

      // random mix on a 128-byte ring
      set_ctrl(5'd5, 1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 300; i++) begin
         int c;
         c = $urandom % 10;
         if (c < 6) send_vec(rnd_vec());
         else if (c < 8) host_rptr($urandom);
         else set_ctrl(5'd5, ($urandom % 3) == 0, $urandom % 2, $urandom % 2);
      end
      check_wptr("R3");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule